// File: doc/BRIEF.md
# Timestamp Ring Buffer With Host Readout

This block collects trigger timestamps from a capture engine and keeps them in a circular store until a host collects them. Each incoming stamp has a seconds value, a coarse count of 8 ns cycles, a sub-cycle fraction in units of 1/4096 of a cycle, and a source tag. The block filters stamps by a per-source enable mask. It gives each stamp it keeps a running 16-bit sequence number, so the host can spot stamps that were lost or overwritten.

The host uses a simple register port. The port carries a valid strobe, a write flag, a 3-bit word address and 32-bit data, and returns read data one cycle later. A write to the advance address moves the oldest stored stamp into a set of readout registers that stay stable. The host then reads the seconds in two halves, the coarse count, and a packed word that holds the sequence, fraction and source. The control word enables capture and sets the mask. It also carries one-shot bits that empty the store and restart numbering. When the store is full, a new stamp replaces the oldest one and a sticky overflow flag is raised.

Top module: `tstamp_ring`

## Requirements
- R1: After reset, the control word (address 0) reads 0x0001_0000: empty flag set, overflow clear, capture disabled, mask zero. The four readout words (addresses 2 to 5) read zero.
- R2: A stamp is stored only when the enable bit (control bit 0) is set and the mask bit (control bits 15:8) indexed by its source is set. Any other stamp leaves the buffer and the sequence counter unchanged.
- R3: A stored stamp takes the current value of the sequence counter. The counter then adds one and wraps from 0xFFFF to 0.
- R4: A write to address 1 pops the oldest stored stamp into the readout registers, so stamps come out in arrival order. Address 2 returns seconds bits 63:32 and address 3 returns bits 31:0. Address 4 returns the coarse count in bits 27:0. Address 5 returns the packed word: source in bits 2:0, bit 3 zero, fraction in bits 15:4, sequence in bits 31:16. Read data appears one cycle after the read request.
- R5: An advance while the buffer is empty leaves every readout register unchanged.
- R6: When a stamp arrives and the buffer already holds DEPTH entries, the oldest entry is discarded and the new one stored. The sticky overflow flag (control bit 17) is set and stays set until a purge.
- R7: Writing control bit 1 empties the buffer at that clock edge and clears the overflow flag. The sequence counter is untouched, and the bit reads back as 0.
- R8: Writing control bit 2 sets the sequence counter to zero without altering stored entries. The bit reads back as 0.
- R9: Control bit 16 reads 1 exactly when the buffer holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Incoming stamp is present this cycle |
| ts_src | input | 3 | Source tag of the stamp |
| ts_sec | input | 64 | Seconds value |
| ts_cyc | input | 28 | Coarse 8 ns cycle count |
| ts_frac | input | 12 | Sub-cycle fraction, 1/4096 cycle units |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
The assertions assume that no stamp arrives in the same cycle as a reset-sequence write. When that collision happens, the stamp keeps the old counter value, and the checks do not cover that case. The assertions also assume that register requests last exactly one cycle, so one write is one advance or one purge. The bench drives every request for a single cycle from the falling edge. It always sets the control word before it sends stamps, and it never lines a stamp up with a control write. The stream of stamps and the host accesses therefore never collide.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int SEC_W   = 64;
    localparam int CYC_W   = 28;
    localparam int FRAC_W  = 12;
    localparam int SEQ_W   = 16;
    localparam int SRC_W   = 3;
    localparam int NUM_SRC = 1 << SRC_W;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_ADV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SECH = 3'd2;
    localparam logic [ADDR_W-1:0] A_SECL = 3'd3;
    localparam logic [ADDR_W-1:0] A_CYC  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PACK = 3'd5;

    localparam int B_EN    = 0;
    localparam int B_PURGE = 1;
    localparam int B_RSEQ  = 2;
    localparam int B_MASK  = 8;
    localparam int B_EMPTY = 16;
    localparam int B_OVF   = 17;

    localparam int PK_SRC  = 0;
    localparam int PK_FRAC = 4;
    localparam int PK_SEQ  = 16;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [CYC_W-1:0]  cyc;
        logic [FRAC_W-1:0] frac;
        logic [SEQ_W-1:0]  seq;
        logic [SRC_W-1:0]  src;
    } stamp_t;

    function automatic logic [DATA_W-1:0] pack_word(input stamp_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PK_SRC  +: SRC_W]  = s.src;
        w[PK_FRAC +: FRAC_W] = s.frac;
        w[PK_SEQ  +: SEQ_W]  = s.seq;
        return w;
    endfunction
endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
    import tsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic               en,
    output logic [NUM_SRC-1:0] mask,
    output logic               purge,
    output logic               rst_seq,
    output logic               advance
);
    typedef struct packed {
        logic               en;
        logic [NUM_SRC-1:0] mask;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  wr_ctrl;

    always_comb begin
        ctrl_d  = ctrl_q;
        wr_ctrl = reg_valid && reg_write && (reg_addr == A_CTRL);
        advance = reg_valid && reg_write && (reg_addr == A_ADV);
        purge   = wr_ctrl && reg_wdata[B_PURGE];
        rst_seq = wr_ctrl && reg_wdata[B_RSEQ];
        if (wr_ctrl) begin
            ctrl_d.en   = reg_wdata[B_EN];
            ctrl_d.mask = reg_wdata[B_MASK +: NUM_SRC];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign en   = ctrl_q.en;
    assign mask = ctrl_q.mask;
endmodule

// File: rtl/tsr_accept.sv
module tsr_accept
    import tsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ts_valid,
    input  logic [SRC_W-1:0]   ts_src,
    input  logic               en,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               purge,
    input  logic               rst_seq,
    output logic               store,
    output logic [SEQ_W-1:0]   seq
);
    typedef struct packed {
        logic [SEQ_W-1:0] seq;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        store = ts_valid && en && mask[ts_src] && !purge;
        if (rst_seq)    acc_d.seq = '0;
        else if (store) acc_d.seq = acc_q.seq + SEQ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign seq = acc_q.seq;
endmodule

// File: rtl/tsr_ring.sv
module tsr_ring
    import tsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  stamp_t push_data,
    input  logic pop,
    input  logic purge,
    output stamp_t head,
    output logic pop_ok,
    output logic empty,
    output logic overflow,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ring_t;

    ring_t  ring_d, ring_q;
    stamp_t mem [DEPTH];
    logic   is_full;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        ring_d  = ring_q;
        is_full = (ring_q.cnt == FULL);
        pop_ok  = pop && (ring_q.cnt != '0) && !purge;
        if (purge) begin
            ring_d = '0;
        end else if (push && pop_ok) begin
            ring_d.wr = step(ring_q.wr);
            ring_d.rd = step(ring_q.rd);
        end else if (push && is_full) begin
            ring_d.wr  = step(ring_q.wr);
            ring_d.rd  = step(ring_q.rd);
            ring_d.ovf = 1'b1;
        end else if (push) begin
            ring_d.wr  = step(ring_q.wr);
            ring_d.cnt = ring_q.cnt + CNT_W'(1);
        end else if (pop_ok) begin
            ring_d.rd  = step(ring_q.rd);
            ring_d.cnt = ring_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (push && !purge) mem[ring_q.wr] <= push_data;
    end

    assign head     = mem[ring_q.rd];
    assign empty    = (ring_q.cnt == '0);
    assign overflow = ring_q.ovf;
    assign count    = ring_q.cnt;
endmodule

// File: rtl/tstamp_ring.sv
module tstamp_ring
    import tsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_valid,
    input  logic [SRC_W-1:0]  ts_src,
    input  logic [SEC_W-1:0]  ts_sec,
    input  logic [CYC_W-1:0]  ts_cyc,
    input  logic [FRAC_W-1:0] ts_frac,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic               en, purge, rst_seq, advance, store;
    logic [NUM_SRC-1:0] mask;
    logic [SEQ_W-1:0]   seq;
    stamp_t             in_stamp, head;
    logic               pop_ok, empty, overflow;
    logic [CNT_W-1:0]   count;

    tsr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .en(en), .mask(mask), .purge(purge),
        .rst_seq(rst_seq), .advance(advance)
    );

    tsr_accept u_accept (
        .clk(clk), .rst_n(rst_n),
        .ts_valid(ts_valid), .ts_src(ts_src),
        .en(en), .mask(mask), .purge(purge), .rst_seq(rst_seq),
        .store(store), .seq(seq)
    );

    always_comb begin
        in_stamp.sec  = ts_sec;
        in_stamp.cyc  = ts_cyc;
        in_stamp.frac = ts_frac;
        in_stamp.seq  = seq;
        in_stamp.src  = ts_src;
    end

    tsr_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(store), .push_data(in_stamp),
        .pop(advance), .purge(purge),
        .head(head), .pop_ok(pop_ok),
        .empty(empty), .overflow(overflow), .count(count)
    );

    typedef struct packed {
        stamp_t            ro;
        logic [DATA_W-1:0] rdata;
    } out_t;

    out_t              out_d, out_q;
    logic [DATA_W-1:0] status;

    always_comb begin
        out_d  = out_q;
        status = '0;
        status[B_EN]               = en;
        status[B_MASK +: NUM_SRC]  = mask;
        status[B_EMPTY]            = empty;
        status[B_OVF]              = overflow;
        if (pop_ok) out_d.ro = head;
        if (reg_valid && !reg_write) begin
            case (reg_addr)
                A_CTRL:  out_d.rdata = status;
                A_SECH:  out_d.rdata = out_q.ro.sec[SEC_W-1 -: DATA_W];
                A_SECL:  out_d.rdata = out_q.ro.sec[DATA_W-1:0];
                A_CYC:   out_d.rdata = DATA_W'(out_q.ro.cyc);
                A_PACK:  out_d.rdata = pack_word(out_q.ro);
                default: out_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign reg_rdata = out_q.rdata;
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk
    import tsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic clk,
    input logic rst_n,
    input logic purge,
    input logic rst_seq,
    input logic advance,
    input logic store,
    input logic ts_valid,
    input logic [SRC_W-1:0] ts_src,
    input logic en,
    input logic [NUM_SRC-1:0] mask,
    input logic empty,
    input logic overflow,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic [SEQ_W-1:0] seq,
    input stamp_t ro
);
    localparam int CNT_W = $clog2(DEPTH+1);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !purge |=> overflow);

    assert_purge_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> empty && !overflow);

    assert_empty_adv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance && empty |=> $stable(ro));

    assert_drop_filtered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid && !(en && mask[ts_src]) && !advance && !purge && !rst_seq
        |=> $stable(count) && $stable(seq));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store && !rst_seq |=> seq == $past(seq) + SEQ_W'(1));

    assert_seq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seq |=> seq == '0);
endmodule

bind tstamp_ring tsr_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .purge(purge), .rst_seq(rst_seq),
    .advance(advance), .store(store), .ts_valid(ts_valid), .ts_src(ts_src),
    .en(en), .mask(mask), .empty(empty), .overflow(overflow),
    .count(count), .seq(seq), .ro(out_q.ro)
);

// File: tb/tb_tstamp_ring.sv
`timescale 1ns/1ps
module tb_tstamp_ring;
    import tsr_pkg::*;
    localparam int DEPTH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ts_valid = 1'b0;
    logic [SRC_W-1:0]  ts_src = '0;
    logic [SEC_W-1:0]  ts_sec = '0;
    logic [CYC_W-1:0]  ts_cyc = '0;
    logic [FRAC_W-1:0] ts_frac = '0;
    logic              reg_valid = 1'b0;
    logic              reg_write = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_pack = '0;

    always #10 clk = ~clk;

    tstamp_ring #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_src(ts_src),
        .ts_sec(ts_sec), .ts_cyc(ts_cyc), .ts_frac(ts_frac),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [63:0] e_sec(input int i);
        logic [31:0] hi, lo;
        hi = 32'hA000_0000 + 32'(i);
        lo = 32'h5000_0000 ^ 32'(i * 7);
        return {hi, lo};
    endfunction
    function automatic logic [27:0] e_cyc(input int i);
        return 28'(i * 1234567);
    endfunction
    function automatic logic [11:0] e_frac(input int i);
        return 12'(i * 37);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic drive(input int src, input int i);
        ts_src = 3'(src); ts_sec = e_sec(i); ts_cyc = e_cyc(i); ts_frac = e_frac(i);
    endtask

    task automatic push(input int src, input int i);
        @(negedge clk);
        ts_valid = 1'b1; drive(src, i);
        @(negedge clk);
        ts_valid = 1'b0;
    endtask

    task automatic pop_check(input int i, input int src, input int seq, input string req);
        logic [31:0] v;
        logic [63:0] s;
        logic [31:0] p;
        s = e_sec(i);
        p = {16'(seq), e_frac(i), 1'b0, 3'(src)};
        reg_wr(A_ADV, 32'h0);
        reg_rd(A_SECH, v); chk(req, 64'(v), 64'(s[63:32]));
        reg_rd(A_SECL, v); chk(req, 64'(v), 64'(s[31:0]));
        reg_rd(A_CYC,  v); chk(req, 64'(v), 64'(e_cyc(i)));
        reg_rd(A_PACK, v); chk(req, 64'(v), 64'(p));
        last_pack = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9: state after reset
        reg_rd(A_CTRL, v); chk("R1 R9 ctrl", 64'(v), 64'h0001_0000);
        for (int a = 2; a <= 5; a++) begin
            reg_rd(3'(a), v); chk("R1 readout", 64'(v), 64'h0);
        end

        // R2: capture disabled, full mask -> nothing stored
        reg_wr(A_CTRL, 32'h0000_FF00);
        push(3, 1);
        reg_rd(A_CTRL, v); chk("R2 disabled", 64'(v), 64'h0001_FF00);

        // R2 R3 R4 R5 R9: sweep every mask over every source
        for (int m = 0; m < 256; m++) begin
            reg_wr(A_CTRL, 32'h7 | (32'(m) << 8));
            for (int s = 0; s < 8; s++) push(s, m * 8 + s);
            k = 0;
            for (int s = 0; s < 8; s++) begin
                if (m[s]) begin
                    pop_check(m * 8 + s, s, k, "R2 R3 R4");
                    k++;
                end
            end
            reg_rd(A_CTRL, v); chk("R9 drained", 64'(v), 64'(32'h0001_0001 | (32'(m) << 8)));
            reg_wr(A_ADV, 32'h0);
            reg_rd(A_PACK, v); chk("R5 empty advance", 64'(v), 64'(last_pack));
        end

        // R6: overflow overwrites oldest
        n = DEPTH + 5;
        reg_wr(A_CTRL, 32'h0000_FF07);
        for (int i = 0; i < n; i++) push(i % 8, 5000 + i);
        reg_rd(A_CTRL, v); chk("R6 ovf set", 64'(v), 64'h0002_FF01);
        for (int j = 5; j < n; j++) pop_check(5000 + j, j % 8, j, "R6 oldest kept");
        reg_rd(A_CTRL, v); chk("R6 ovf sticky", 64'(v), 64'h0003_FF01);

        // R7: purge clears flag, keeps sequence
        push(1, 6000);
        reg_wr(A_CTRL, 32'h0000_FF03);
        reg_rd(A_CTRL, v); chk("R7 purge", 64'(v), 64'h0001_FF01);
        push(2, 7000);
        // R8: reset sequence keeps contents
        reg_wr(A_CTRL, 32'h0000_FF05);
        push(4, 7001);
        reg_rd(A_CTRL, v); chk("R8 no purge", 64'(v), 64'h0000_FF01);
        pop_check(7000, 2, n + 1, "R7 seq kept");
        pop_check(7001, 4, 0, "R8 seq zero");

        // R3 R6: sequence wrap over a long stream
        n = 65538;
        reg_wr(A_CTRL, 32'h0000_FF07);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ts_valid = 1'b1; drive(i % 8, i);
        end
        @(negedge clk);
        ts_valid = 1'b0;
        reg_rd(A_CTRL, v); chk("R6 stream ovf", 64'(v), 64'h0002_FF01);
        for (int j = n - DEPTH; j < n; j++) pop_check(j, j % 8, j & 16'hFFFF, "R3 wrap");
        reg_rd(A_CTRL, v); chk("R9 empty", 64'(v), 64'h0003_FF01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule